// File: doc/BRIEF.md
# Dual-Channel Fault Report Serial Interface

This block is the serial front end of a two-channel solenoid current controller. A host reaches it as a slave on a 16-bit, full-duplex serial link with a fixed mode: the clock idles low, input data is sampled on the rising edge, output data changes on the falling edge, and the most significant bit goes first. The serial pins are brought into the system clock domain through two-flop synchronisers and sampled there, so the serial clock must be well below a quarter of the system clock.

The analog side reports four fault levels for each channel: short to battery, open load or short to ground, overtemperature, and command out of range. Each fault is latched until a status response has shown it to the host. The reply to a frame is selected by the command of the previous valid frame. At the start of a frame (the chip select falling edge) the reply word is built and loaded into the transmit shifter. When that reply is a status word, the latched flags it carries are the only ones cleared when the frame completes. A register-read command selects a 3-bit register number and a channel on two output ports. The core returns an 8-bit value, and that value is sent back in the reply of the next frame. A configuration command writes one fault-typing enable bit per channel.

The frame controller has five states. IDLE waits for chip select to go low; that edge (the LOAD transition) loads the reply word and moves to SHIFT. SHIFT counts rising edges; the sixteenth edge moves to FULL, and chip select going high early aborts back to IDLE. FULL moves to COMMIT when chip select rises, or to OVER on a seventeenth rising edge. OVER returns to IDLE when chip select rises and applies nothing. COMMIT lasts one cycle: it applies the command and the latch clears, then returns to IDLE.

Top module: `spi_diag_if`

## Requirements
- R1: After reset the output enable is low, both fault-typing enables are 0, the register-select outputs are 0, and no fault is latched.
- R2: The serial output enable is high while chip select is low and low while chip select is high.
- R3: Frames are 16 bits, MSB first. Input bits are sampled on serial clock rising edges and output bits change on falling edges. Command bit 15 selects the channel and bits 14:13 the operation: 00 status, 01 configure, 10 register read, 11 no operation.
- R4: A status reply has this layout. Bit 15 is the channel and bits 14:13 echo the operation code. Bit 12 is the OR of the latched open-load, short-to-battery and overtemperature flags. Bit 11 is command-out-of-range. Bits 10, 9 and 8 are open-load, short-to-battery and overtemperature. Bits 7:0 are zero.
- R5: A fault level that is high for even one system clock stays latched after the level falls.
- R6: After a valid status reply, exactly the flags set in that reply are cleared. The other channel is not touched.
- R7: A fault that arrives after a frame's reply was loaded stays latched and appears in the next status reply.
- R8: A frame with any rising-edge count other than 16 is discarded. It clears no flag, applies no command, and does not change the next reply.
- R9: A configure command copies command bit 5 into that channel's fault-typing enable. Bits 12:6 have no effect.
- R10: A register-read command drives command bits 10:8 on the register-select output and bit 15 on the channel output. The next reply is {channel, 10, 00, register number, value}, and no flag is cleared by it.
- R11: The first frame after reset replies with a status word for channel 0.
- R12: A flag whose fault level is still high when its reply completes remains latched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sck | input | 1 | Serial clock, idles low |
| spi_csn | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial command data |
| spi_miso | output | 1 | Serial reply data |
| spi_miso_oe | output | 1 | Drive enable for the reply pin (low means high impedance) |
| flt_vsht | input | NCH | Short-to-battery fault level per channel |
| flt_olsg | input | NCH | Open-load or short-to-ground fault level per channel |
| flt_otmp | input | NCH | Overtemperature fault level per channel |
| flt_cor | input | NCH | Command-out-of-range level per channel |
| ft_en | output | NCH | Fault-typing enable per channel |
| rd_ch | output | 1 | Channel of the last register-read command |
| rd_id | output | 3 | Register number of the last register-read command |
| rd_val | input | 8 | Register value returned by the core for rd_ch and rd_id |

## Verification
The assertions assume the serial pins change slowly compared with the system clock, so that each serial edge is seen as exactly one synchronised edge. They also assume chip select never falls during the single COMMIT cycle. The bench holds every serial half period for eight system clocks and waits sixteen clocks after chip select rises, so it stays inside both assumptions. Fault levels are pulsed for a few clocks between frames. They are applied in the middle of a frame only in the test for faults that arrive after the reply has been loaded.

// File: rtl/sdi_pkg.sv
package sdi_pkg;
    localparam int FRAME_W = 16;
    localparam int CNT_W   = $clog2(FRAME_W) + 1;
    localparam int NFLT    = 4;
    localparam int ID_W    = 3;
    localparam int VAL_W   = 8;

    // command field positions that the decoder depends on
    localparam int POS_CH  = 15;
    localparam int POS_OPH = 14;
    localparam int POS_OPL = 13;
    localparam int POS_FT  = 5;
    localparam int POS_IDH = 10;
    localparam int POS_IDL = 8;

    // latch bit order inside one channel
    localparam int FL_VSHT = 0;
    localparam int FL_OLSG = 1;
    localparam int FL_OTMP = 2;
    localparam int FL_COR  = 3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SHIFT,
        ST_FULL,
        ST_OVER,
        ST_COMMIT
    } fr_state_t;

    typedef enum logic [1:0] {
        OP_STATUS = 2'b00,
        OP_CONFIG = 2'b01,
        OP_REGRD  = 2'b10,
        OP_NOP    = 2'b11
    } op_t;
endpackage

// File: rtl/sdi_sync.sv
module sdi_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_i,
    input  logic csn_i,
    input  logic mosi_i,
    output logic sck_rise,
    output logic sck_fall,
    output logic csn_fall,
    output logic csn_rise,
    output logic csn_lvl,
    output logic mosi_lvl
);
    logic [1:0] sck_m, csn_m, mosi_m;
    logic       sck_d, csn_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_m  <= 2'b00;
            csn_m  <= 2'b11;
            mosi_m <= 2'b00;
            sck_d  <= 1'b0;
            csn_d  <= 1'b1;
        end else begin
            sck_m  <= {sck_m[0], sck_i};
            csn_m  <= {csn_m[0], csn_i};
            mosi_m <= {mosi_m[0], mosi_i};
            sck_d  <= sck_m[1];
            csn_d  <= csn_m[1];
        end
    end

    assign sck_rise = sck_m[1] & ~sck_d;
    assign sck_fall = ~sck_m[1] & sck_d;
    assign csn_fall = ~csn_m[1] & csn_d;
    assign csn_rise = csn_m[1] & ~csn_d;
    assign csn_lvl  = csn_m[1];
    assign mosi_lvl = mosi_m[1];
endmodule

// File: rtl/sdi_frame.sv
module sdi_frame
    import sdi_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sck_rise,
    input  logic               sck_fall,
    input  logic               csn_fall,
    input  logic               csn_rise,
    input  logic               mosi_lvl,
    input  logic [FRAME_W-1:0] resp_word,
    output logic               load,
    output logic               commit,
    output logic               so_bit,
    output logic               cmd_ch,
    output logic [1:0]         cmd_op,
    output logic               cmd_ft,
    output logic [ID_W-1:0]    cmd_id
);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(FRAME_W - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(FRAME_W);

    fr_state_t          state_q, state_d;
    logic [FRAME_W-1:0] rx_sr, tx_sr;
    logic [CNT_W-1:0]   bit_cnt;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (csn_fall) state_d = ST_SHIFT;
            ST_SHIFT: begin
                if (csn_rise)                             state_d = ST_IDLE;
                else if (sck_rise && bit_cnt == LAST_CNT) state_d = ST_FULL;
            end
            ST_FULL: begin
                if (csn_rise)      state_d = ST_COMMIT;
                else if (sck_rise) state_d = ST_OVER;
            end
            ST_OVER:   if (csn_rise) state_d = ST_IDLE;
            ST_COMMIT: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        load   = (state_q == ST_IDLE) && csn_fall;
        commit = (state_q == ST_COMMIT);
        so_bit = tx_sr[FRAME_W-1];
        cmd_ch = rx_sr[POS_CH];
        cmd_op = rx_sr[POS_OPH:POS_OPL];
        cmd_ft = rx_sr[POS_FT];
        cmd_id = rx_sr[POS_IDH:POS_IDL];
    end

    // shifters and bit counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_sr   <= '0;
            tx_sr   <= '0;
            bit_cnt <= '0;
        end else begin
            if (load) begin
                tx_sr   <= resp_word;
                bit_cnt <= '0;
            end else begin
                if (state_q == ST_SHIFT && sck_rise) begin
                    rx_sr   <= {rx_sr[FRAME_W-2:0], mosi_lvl};
                    bit_cnt <= bit_cnt + 1'b1;
                end
                if (state_q != ST_IDLE && state_q != ST_COMMIT && sck_fall)
                    tx_sr <= {tx_sr[FRAME_W-2:0], 1'b0};
            end
        end
    end

    p_cnt_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SHIFT) |-> (bit_cnt < FULL_CNT));
    p_full_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FULL) |-> (bit_cnt == FULL_CNT));
    p_commit_from_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COMMIT) |-> ($past(state_q) == ST_FULL));
    p_commit_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> !commit);
endmodule

// File: rtl/sdi_fault_latch.sv
module sdi_fault_latch #(
    parameter int NF = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NF-1:0] raw,
    input  logic [NF-1:0] clr,
    output logic [NF-1:0] lat
);
    // an active level always wins over a clear in the same cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lat <= '0;
        else        lat <= (lat & ~clr) | raw;
    end

    p_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((lat & $past(raw)) == $past(raw)));
    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(lat) & ~$past(clr)) & ~lat) == '0));
    p_no_spurious_r6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((lat & ~$past(lat) & ~$past(raw)) == '0));
endmodule

// File: rtl/spi_diag_if.sv
module spi_diag_if
    import sdi_pkg::*;
#(
    parameter int NCH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             spi_sck,
    input  logic             spi_csn,
    input  logic             spi_mosi,
    output logic             spi_miso,
    output logic             spi_miso_oe,
    input  logic [NCH-1:0]   flt_vsht,
    input  logic [NCH-1:0]   flt_olsg,
    input  logic [NCH-1:0]   flt_otmp,
    input  logic [NCH-1:0]   flt_cor,
    output logic [NCH-1:0]   ft_en,
    output logic             rd_ch,
    output logic [ID_W-1:0]  rd_id,
    input  logic [VAL_W-1:0] rd_val
);
    localparam int CH_W = 1;  // channel field is one command bit

    logic sck_rise, sck_fall, csn_fall, csn_rise, csn_lvl, mosi_lvl;
    logic load, commit, so_bit;
    logic cmd_ch, cmd_ft;
    logic [1:0] cmd_op;
    logic [ID_W-1:0] cmd_id;
    logic [FRAME_W-1:0] resp_word;

    logic [NFLT-1:0] raw_c [NCH];
    logic [NFLT-1:0] clr_c [NCH];
    logic [NFLT-1:0] lat_c [NCH];

    logic [CH_W-1:0] pend_ch, snap_ch;
    op_t             pend_op;
    logic [NFLT-1:0] snap_mask, lat_p;
    logic [NCH-1:0]  ft_en_q;
    logic            rd_ch_q;
    logic [ID_W-1:0] rd_id_q;

    sdi_sync u_sync (
        .clk(clk), .rst_n(rst_n),
        .sck_i(spi_sck), .csn_i(spi_csn), .mosi_i(spi_mosi),
        .sck_rise(sck_rise), .sck_fall(sck_fall),
        .csn_fall(csn_fall), .csn_rise(csn_rise),
        .csn_lvl(csn_lvl), .mosi_lvl(mosi_lvl)
    );

    sdi_frame u_frame (
        .clk(clk), .rst_n(rst_n),
        .sck_rise(sck_rise), .sck_fall(sck_fall),
        .csn_fall(csn_fall), .csn_rise(csn_rise),
        .mosi_lvl(mosi_lvl), .resp_word(resp_word),
        .load(load), .commit(commit), .so_bit(so_bit),
        .cmd_ch(cmd_ch), .cmd_op(cmd_op), .cmd_ft(cmd_ft), .cmd_id(cmd_id)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        assign raw_c[c] = {flt_cor[c], flt_otmp[c], flt_olsg[c], flt_vsht[c]};
        sdi_fault_latch #(.NF(NFLT)) u_lat (
            .clk(clk), .rst_n(rst_n),
            .raw(raw_c[c]), .clr(clr_c[c]), .lat(lat_c[c])
        );
    end

    // clear only what the completed reply carried
    always_comb begin
        for (int c = 0; c < NCH; c++)
            clr_c[c] = (commit && snap_ch == CH_W'(c)) ? snap_mask : '0;
    end

    // reply word for the frame about to start
    always_comb begin
        lat_p = lat_c[pend_ch];
        if (pend_op == OP_REGRD)
            resp_word = {pend_ch, OP_REGRD, 2'b00, rd_id_q, rd_val};
        else
            resp_word = {pend_ch, pend_op,
                         |{lat_p[FL_OLSG], lat_p[FL_VSHT], lat_p[FL_OTMP]},
                         lat_p[FL_COR], lat_p[FL_OLSG], lat_p[FL_VSHT],
                         lat_p[FL_OTMP], 8'h00};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_ch   <= '0;
            pend_op   <= OP_STATUS;
            snap_ch   <= '0;
            snap_mask <= '0;
            ft_en_q   <= '0;
            rd_ch_q   <= 1'b0;
            rd_id_q   <= '0;
        end else begin
            if (load) begin
                snap_ch   <= pend_ch;
                snap_mask <= (pend_op == OP_REGRD) ? '0 : lat_p;
            end
            if (commit) begin
                pend_ch <= cmd_ch;
                pend_op <= op_t'(cmd_op);
                if (op_t'(cmd_op) == OP_CONFIG)
                    ft_en_q[cmd_ch] <= cmd_ft;
                if (op_t'(cmd_op) == OP_REGRD) begin
                    rd_ch_q <= cmd_ch;
                    rd_id_q <= cmd_id;
                end
            end
        end
    end

    assign spi_miso    = so_bit;
    assign spi_miso_oe = ~csn_lvl;
    assign ft_en       = ft_en_q;
    assign rd_ch       = rd_ch_q;
    assign rd_id       = rd_id_q;

    p_oe_commit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> !spi_miso_oe);
    p_oe_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> spi_miso_oe);
    p_cfg_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(ft_en_q));
    p_rd_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> ($stable(rd_id_q) && $stable(rd_ch_q)));
    p_no_commit_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |-> (clr_c[0] == '0));
endmodule

// File: tb/sim_spi_diag_if.sv
module sim_spi_diag_if;
    localparam int HP = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sck = 1'b0, csn = 1'b1, mosi = 1'b0;
    logic miso, miso_oe;
    logic [1:0] f_vsht = '0, f_olsg = '0, f_otmp = '0, f_cor = '0;
    logic [1:0] ft_en;
    logic       rd_ch;
    logic [2:0] rd_id;
    logic [7:0] rd_val;

    int total = 0;
    int bad = 0;

    // model state
    logic [3:0] m_lat [2];
    logic [3:0] m_hold [2];
    logic [1:0] m_op;
    logic       m_ch;
    logic [2:0] m_id;
    logic       m_rch;
    logic [1:0] m_ft;

    always #10 clk = ~clk;

    assign rd_val = {rd_ch, 1'b0, rd_id, 3'b101};

    spi_diag_if u0 (
        .clk(clk), .rst_n(rst_n),
        .spi_sck(sck), .spi_csn(csn), .spi_mosi(mosi),
        .spi_miso(miso), .spi_miso_oe(miso_oe),
        .flt_vsht(f_vsht), .flt_olsg(f_olsg), .flt_otmp(f_otmp), .flt_cor(f_cor),
        .ft_en(ft_en), .rd_ch(rd_ch), .rd_id(rd_id), .rd_val(rd_val)
    );

    task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic drive_raw(input int ch, input logic [3:0] m);
        f_vsht[ch] = m[0];
        f_olsg[ch] = m[1];
        f_otmp[ch] = m[2];
        f_cor[ch]  = m[3];
    endtask

    task automatic pulse_fault(input int ch, input logic [3:0] m);
        @(negedge clk);
        drive_raw(ch, m | m_hold[ch]);
        repeat (3) @(negedge clk);
        drive_raw(ch, m_hold[ch]);
        m_lat[ch] = m_lat[ch] | m;
        repeat (4) @(negedge clk);
    endtask

    task automatic hold_fault(input int ch, input logic [3:0] m);
        @(negedge clk);
        m_hold[ch] = m;
        drive_raw(ch, m);
        m_lat[ch] = m_lat[ch] | m;
        repeat (4) @(negedge clk);
    endtask

    function automatic logic [15:0] cmd(input logic ch, input logic [1:0] op, input logic [12:0] low);
        return {ch, op, low};
    endfunction

    // one transfer; checks the reply of a full frame against the model
    task automatic frame(input logic [15:0] c, input int nbits, input logic [3:0] inj,
                         input int inj_ch, input string req);
        logic [15:0] exp, got;
        logic [3:0]  snap, l;
        logic        snap_ch;
        l = m_lat[m_ch];
        if (m_op == 2'b10)
            exp = {m_ch, 2'b10, 2'b00, m_id, m_rch, 1'b0, m_id, 3'b101};
        else
            exp = {m_ch, m_op, |l[2:0], l[3], l[1], l[0], l[2], 8'h00};
        snap    = (m_op == 2'b10) ? 4'h0 : l;
        snap_ch = m_ch;
        got = '0;
        @(negedge clk);
        csn = 1'b0;
        repeat (HP) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            mosi = (i < 16) ? c[15 - i] : 1'b0;
            repeat (HP) @(negedge clk);
            got = {got[14:0], miso};
            if (i == 2) chk("R2", {15'd0, miso_oe}, 16'd1);
            if (i == 4 && inj != 4'h0) begin
                drive_raw(inj_ch, inj | m_hold[inj_ch]);
                repeat (3) @(negedge clk);
                drive_raw(inj_ch, m_hold[inj_ch]);
            end
            sck = 1'b1;
            repeat (HP) @(negedge clk);
            sck = 1'b0;
        end
        repeat (HP) @(negedge clk);
        csn = 1'b1;
        repeat (2 * HP) @(negedge clk);
        chk("R2", {15'd0, miso_oe}, 16'd0);
        if (nbits == 16) begin
            chk(req, got, exp);
            m_lat[snap_ch] = m_lat[snap_ch] & ~snap;
            m_lat[0] = m_lat[0] | m_hold[0];
            m_lat[1] = m_lat[1] | m_hold[1];
            m_op = c[14:13];
            m_ch = c[15];
            if (c[14:13] == 2'b01) m_ft[c[15]] = c[5];
            if (c[14:13] == 2'b10) begin
                m_id  = c[10:8];
                m_rch = c[15];
            end
        end
        m_lat[inj_ch] = m_lat[inj_ch] | inj;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        m_lat[0] = '0; m_lat[1] = '0;
        m_hold[0] = '0; m_hold[1] = '0;
        m_op = 2'b00; m_ch = 1'b0; m_id = '0; m_rch = 1'b0; m_ft = '0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R1 reset state
        chk("R1", {15'd0, miso_oe}, 16'd0);
        chk("R1", {14'd0, ft_en}, 16'd0);
        chk("R1", {12'd0, rd_ch, rd_id}, 16'd0);

        // R11 first reply is an empty status word for channel 0
        frame(cmd(1'b0, 2'b00, 13'd0), 16, 4'h0, 0, "R11");

        // R3 R4 R5 R6 sweep of every flag pattern on both channels
        for (int ch = 0; ch < 2; ch++) begin
            for (int m = 0; m < 16; m++) begin
                pulse_fault(ch, 4'(m));
                frame(cmd(1'(ch), 2'b00, 13'd0), 16, 4'h0, 0, "R4");
                frame(cmd(1'(ch), 2'b00, 13'd0), 16, 4'h0, 0, "R3");
            end
        end

        // R6 clear is limited to the channel reported
        pulse_fault(0, 4'b1010);
        pulse_fault(1, 4'b0101);
        frame(cmd(1'b1, 2'b00, 13'd0), 16, 4'h0, 0, "R6");
        frame(cmd(1'b1, 2'b00, 13'd0), 16, 4'h0, 0, "R6");
        frame(cmd(1'b0, 2'b00, 13'd0), 16, 4'h0, 0, "R6");
        frame(cmd(1'b0, 2'b00, 13'd0), 16, 4'h0, 0, "R6");
        frame(cmd(1'b0, 2'b00, 13'd0), 16, 4'h0, 0, "R6");

        // R7 fault arriving mid-frame survives to the next reply
        frame(cmd(1'b0, 2'b00, 13'd0), 16, 4'b0100, 0, "R7");
        frame(cmd(1'b0, 2'b00, 13'd0), 16, 4'h0, 0, "R7");
        frame(cmd(1'b0, 2'b00, 13'd0), 16, 4'h0, 0, "R7");

        // R12 level still active during the read keeps the flag
        hold_fault(1, 4'b1001);
        frame(cmd(1'b1, 2'b00, 13'd0), 16, 4'h0, 0, "R12");
        frame(cmd(1'b1, 2'b00, 13'd0), 16, 4'h0, 0, "R12");
        hold_fault(1, 4'b0000);
        frame(cmd(1'b1, 2'b00, 13'd0), 16, 4'h0, 0, "R12");
        frame(cmd(1'b1, 2'b00, 13'd0), 16, 4'h0, 0, "R12");

        // R8 short and long frames are discarded
        pulse_fault(1, 4'b0110);
        frame(cmd(1'b1, 2'b00, 13'd0), 16, 4'h0, 0, "R8");
        frame(cmd(1'b1, 2'b00, 13'd0), 10, 4'h0, 0, "R8");
        frame(cmd(1'b0, 2'b01, 13'h0020), 17, 4'h0, 0, "R8");
        chk("R8", {14'd0, ft_en}, {14'd0, m_ft});
        frame(cmd(1'b0, 2'b10, 13'h0300), 5, 4'h0, 0, "R8");
        chk("R8", {12'd0, rd_ch, rd_id}, 16'd0);
        frame(cmd(1'b1, 2'b00, 13'd0), 16, 4'h0, 0, "R8");
        frame(cmd(1'b1, 2'b00, 13'd0), 16, 4'h0, 0, "R8");

        // R9 configure: only bit 5 matters
        for (int v = 0; v < 128; v += 9) begin
            for (int ch = 0; ch < 2; ch++) begin
                frame(cmd(1'(ch), 2'b01, {6'(v), 1'(v >> 1), 5'(v)}), 16, 4'h0, 0, "R9");
                chk("R9", {14'd0, ft_en}, {14'd0, m_ft});
            end
        end
        frame(cmd(1'b0, 2'b01, 13'h1FC0), 16, 4'h0, 0, "R9");
        chk("R9", {14'd0, ft_en}, {14'd0, m_ft});

        // R10 register read for every number on both channels, no clearing
        pulse_fault(0, 4'b0111);
        for (int ch = 0; ch < 2; ch++) begin
            for (int id = 0; id < 8; id++) begin
                frame(cmd(1'(ch), 2'b10, {2'b00, 3'(id), 8'h00}), 16, 4'h0, 0, "R10");
                chk("R10", {12'd0, rd_ch, rd_id}, {12'd0, m_rch, m_id});
            end
        end
        frame(cmd(1'b0, 2'b00, 13'd0), 16, 4'h0, 0, "R10");
        frame(cmd(1'b0, 2'b11, 13'd0), 16, 4'h0, 0, "R10");
        frame(cmd(1'b0, 2'b00, 13'd0), 16, 4'h0, 0, "R10");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule